// File: doc/BRIEF.md
# Edge-Driven Step Chart Controller

This block runs a fixed sequential function chart in hardware. Each step has one flag bit, so exactly the active steps are set in a one-hot style vector. Boolean condition inputs are turned into events by rising-edge detection, and transitions fire only on those events. All transitions are worked out from the state held in the registers, and every step flag changes on the same clock edge. Firing a transition therefore never depends on the order in which the logic is written.

The chart has nine steps. From an idle step, a start event arms the chart. An exclusive choice follows, with a left path and a right path. Either path then splits into two parallel branches. The two branches meet again at a join into a merge step. The merge step leaves in one of two ways: a plant abort event, or one of two controller commands. Either way the chart loops back. A command is issued as a single-cycle pulse in the same cycle as the transition that chooses it. A sticky flag reports any cycle in which both exclusive paths are active.

Top module: `step_chart_ctrl`

## Requirements
- R1: While `rst` is high, `step_o`, `cmd_o` and `excl_err_o` are all zero. On the first clock edge with `rst` low, only the idle step becomes active: `step_o` reads 9'h001.
- R2: A transition fires only when its input was low in the previous cycle and is high in the current cycle. An input that stays high fires nothing, and neither does an edge on an input that the active steps do not use.
- R3: A transition sets its destination step and clears its source step on the same clock edge, so source and destination are never both active. If the same edge both sets and clears a bit, the clear takes effect.
- R4: The armed step (bit 1) moves to the left step (bit 2) on an edge of `cond_i[1]`. It moves to the right step (bit 3) on an edge of `cond_i[2]`. When both edges arrive in the same cycle, only the left step is entered.
- R5: An edge of `cond_i[3]` while the left or right step is active starts both branches at once (bits 4 and 5) and clears the source step.
- R6: An edge of `cond_i[5]` moves to the merge step (bit 8) only when both branch-end steps (bits 6 and 7) are active. It then clears both of them. With only one branch end active, the edge has no effect.
- R7: Branch A advances from bit 4 to bit 6 on an edge of `cond_i[3]`. The edge that starts the branches does not also advance branch A. Advancing needs `cond_i[3]` to fall and then rise again.
- R8: The merge step stays active for one cycle and then issues exactly one command, as a one-cycle pulse in the same cycle as its transition. If `cond_i[7]` is high, the command is retry (`cmd_o` = 2'b10, to the armed step). If `cond_i[7]` is low, the command is finish (`cmd_o` = 2'b01, to the idle step).
- R9: An edge of `cond_i[6]` while the merge step is active returns the chart to the idle step with no command pulse. This takes priority over both commands.
- R10: `excl_err_o` is a sticky flag. It is set once the left and right steps have ever been active together, and it stays low in correct operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 8 | Condition inputs: 0 start, 1 left, 2 right, 3 branch/advance A, 4 advance B, 5 join, 6 abort, 7 retry select (level) |
| step_o | output | 9 | Active steps: 0 idle, 1 armed, 2 left, 3 right, 4 A0, 5 B0, 6 A1, 7 B1, 8 merge |
| cmd_o | output | 2 | One-cycle command pulses: bit 0 finish, bit 1 retry |
| excl_err_o | output | 1 | Sticky flag for left and right steps both active |

## Verification
On every cycle, the assertions check these properties:
- any step clear issued by the transition logic has taken effect one edge later;
- the exclusive pair holds at most one active step;
- command pulses are one-hot and last a single cycle;
- any clear that is not commanded is backed by an input edge;
- the merge step is entered only from a completed join.

Some behaviours only the bench's scenarios can show:
- left-over-right priority when both edges arrive together;
- a steady high input that changes nothing;
- the fork edge that must not advance branch A;
- the blocked join;
- the abort that wins over a retry command.

// File: rtl/step_chart_pkg.sv
package step_chart_pkg;

    localparam int N_STEP = 9;
    localparam int N_COND = 8;
    localparam int N_CMD  = 2;

    // step indices
    localparam int ST_IDLE  = 0;
    localparam int ST_ARM   = 1;
    localparam int ST_LEFT  = 2;
    localparam int ST_RIGHT = 3;
    localparam int ST_A0    = 4;
    localparam int ST_B0    = 5;
    localparam int ST_A1    = 6;
    localparam int ST_B1    = 7;
    localparam int ST_MERGE = 8;

    // condition input indices
    localparam int IN_START = 0;
    localparam int IN_LEFT  = 1;
    localparam int IN_RIGHT = 2;
    localparam int IN_ADV_A = 3;
    localparam int IN_ADV_B = 4;
    localparam int IN_JOIN  = 5;
    localparam int IN_ABORT = 6;
    localparam int IN_RETRY = 7;

    typedef enum logic [N_CMD-1:0] {
        CMD_NONE   = 2'b00,
        CMD_FINISH = 2'b01,
        CMD_RETRY  = 2'b10
    } cmd_e;

    typedef logic [N_STEP-1:0] step_vec_t;

    typedef struct packed {
        step_vec_t set;
        step_vec_t clr;
        cmd_e      cmd;
    } step_req_t;

    function automatic step_vec_t step_bit(input int idx);
        step_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    // clear dominates set
    function automatic step_vec_t apply_req(input step_vec_t cur,
                                            input step_vec_t set,
                                            input step_vec_t clr);
        return (cur | set) & ~clr;
    endfunction

    function automatic logic over_one(input step_vec_t v);
        return $countones(v) > 1;
    endfunction

    localparam step_vec_t EXCL_MASK = step_bit(ST_LEFT) | step_bit(ST_RIGHT);
    localparam step_vec_t IDLE_VEC  = step_bit(ST_IDLE);

endpackage

// File: rtl/step_chart_edge.sv
module step_chart_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sig_i;
    end

    assign rise_o = sig_i & ~prev_q;

endmodule

// File: rtl/step_chart_net.sv
module step_chart_net
    import step_chart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  step_vec_t         step_i,
    input  logic [N_COND-1:0] rise_i,
    input  logic [N_COND-1:0] level_i,
    output step_req_t         req_o
);
    logic t_start, t_left, t_right, t_fork_l, t_fork_r;
    logic t_adv_a, t_adv_b, t_join, t_abort, t_retry, t_finish;

    always_comb begin
        t_start  = step_i[ST_IDLE]  & rise_i[IN_START];
        t_left   = step_i[ST_ARM]   & rise_i[IN_LEFT];
        t_right  = step_i[ST_ARM]   & rise_i[IN_RIGHT] & ~rise_i[IN_LEFT];
        t_fork_l = step_i[ST_LEFT]  & rise_i[IN_ADV_A];
        t_fork_r = step_i[ST_RIGHT] & rise_i[IN_ADV_A];
        t_adv_a  = step_i[ST_A0]    & rise_i[IN_ADV_A];
        t_adv_b  = step_i[ST_B0]    & rise_i[IN_ADV_B];
        t_join   = step_i[ST_A1] & step_i[ST_B1] & rise_i[IN_JOIN];
        t_abort  = step_i[ST_MERGE] & rise_i[IN_ABORT];
        t_retry  = step_i[ST_MERGE] & ~rise_i[IN_ABORT] & level_i[IN_RETRY];
        t_finish = step_i[ST_MERGE] & ~rise_i[IN_ABORT] & ~level_i[IN_RETRY];

        req_o = '{set: '0, clr: '0, cmd: CMD_NONE};

        req_o.set[ST_ARM]   = t_start | t_retry;
        req_o.set[ST_LEFT]  = t_left;
        req_o.set[ST_RIGHT] = t_right;
        req_o.set[ST_A0]    = t_fork_l | t_fork_r;
        req_o.set[ST_B0]    = t_fork_l | t_fork_r;
        req_o.set[ST_A1]    = t_adv_a;
        req_o.set[ST_B1]    = t_adv_b;
        req_o.set[ST_MERGE] = t_join;
        req_o.set[ST_IDLE]  = t_abort | t_finish;

        req_o.clr[ST_IDLE]  = t_start;
        req_o.clr[ST_ARM]   = t_left | t_right;
        req_o.clr[ST_LEFT]  = t_fork_l;
        req_o.clr[ST_RIGHT] = t_fork_r;
        req_o.clr[ST_A0]    = t_adv_a;
        req_o.clr[ST_B0]    = t_adv_b;
        req_o.clr[ST_A1]    = t_join;
        req_o.clr[ST_B1]    = t_join;
        req_o.clr[ST_MERGE] = t_abort | t_retry | t_finish;

        if (t_retry)       req_o.cmd = CMD_RETRY;
        else if (t_finish) req_o.cmd = CMD_FINISH;
    end

    // a clear without a command must come from an input edge (R2)
    p_edge_only_r2: assert property (@(posedge clk) disable iff (rst)
        (req_o.cmd == CMD_NONE && req_o.clr != '0) |-> (rise_i != '0));

endmodule

// File: rtl/step_chart_reg.sv
module step_chart_reg
    import step_chart_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  step_req_t        req_i,
    output step_vec_t        step_o,
    output logic [N_CMD-1:0] cmd_o,
    output logic             excl_o
);
    step_vec_t        step_q;
    step_vec_t        step_nxt;
    logic [N_CMD-1:0] cmd_q;
    logic             started_q;
    logic             excl_q;

    always_comb begin
        step_nxt = apply_req(step_q,
                             req_i.set | (started_q ? '0 : IDLE_VEC),
                             req_i.clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q    <= '0;
            cmd_q     <= '0;
            started_q <= 1'b0;
            excl_q    <= 1'b0;
        end else begin
            step_q    <= step_nxt;
            cmd_q     <= req_i.cmd;
            started_q <= 1'b1;
            excl_q    <= excl_q | over_one(step_nxt & EXCL_MASK);
        end
    end

    assign step_o = step_q;
    assign cmd_o  = cmd_q;
    assign excl_o = excl_q;

    p_init_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> (step_q == IDLE_VEC));

    p_clear_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (req_i.clr != '0) |=> ((step_q & $past(req_i.clr)) == '0));

    p_excl_pair_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(step_q & EXCL_MASK));

endmodule

// File: rtl/step_chart_ctrl.sv
module step_chart_ctrl
    import step_chart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_COND-1:0] cond_i,
    output logic [N_STEP-1:0] step_o,
    output logic [N_CMD-1:0]  cmd_o,
    output logic              excl_err_o
);
    logic [N_COND-1:0] rise;
    step_req_t         req;

    step_chart_edge #(.W(N_COND)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (cond_i),
        .rise_o (rise)
    );

    step_chart_net u_net (
        .clk     (clk),
        .rst     (rst),
        .step_i  (step_o),
        .rise_i  (rise),
        .level_i (cond_i),
        .req_o   (req)
    );

    step_chart_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req),
        .step_o (step_o),
        .cmd_o  (cmd_o),
        .excl_o (excl_err_o)
    );

    p_cmd_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_o));

    p_cmd_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_o != '0) |=> (cmd_o == '0));

    p_cmd_moves_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_o != '0) |-> (!step_o[ST_MERGE] && $past(step_o[ST_MERGE])));

    p_join_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(step_o[ST_MERGE]) |-> $past(step_o[ST_A1] && step_o[ST_B1]));

endmodule

// File: tb/step_chart_ctrl_bench.sv
module step_chart_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cond = '0;
    logic [8:0] step;
    logic [1:0] cmd;
    logic       excl;

    int n_run  = 0;
    int n_fail = 0;
    bit compare_on = 1'b0;

    always #2.5 clk = ~clk;

    step_chart_ctrl u_step_chart_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cond_i     (cond),
        .step_o     (step),
        .cmd_o      (cmd),
        .excl_err_o (excl)
    );

    // behavioural reference: walk each active step and move its token
    logic [8:0] m_step = '0;
    logic [1:0] m_cmd  = '0;
    logic [7:0] m_prev = '0;
    bit         m_started = 1'b0;

    always @(posedge clk) begin
        logic [8:0] cur, nxt;
        logic [7:0] ev;
        logic [1:0] c;
        if (rst) begin
            m_step = '0; m_cmd = '0; m_prev = '0; m_started = 1'b0;
        end else begin
            cur = m_step; nxt = cur; c = 2'b00;
            ev = cond & ~m_prev;
            if (!m_started) nxt[0] = 1'b1;
            if (cur[0] && ev[0]) begin nxt[0] = 0; nxt[1] = 1; end
            if (cur[1]) begin
                if (ev[1])      begin nxt[1] = 0; nxt[2] = 1; end
                else if (ev[2]) begin nxt[1] = 0; nxt[3] = 1; end
            end
            for (int s = 2; s <= 3; s++)
                if (cur[s] && ev[3]) begin nxt[s] = 0; nxt[4] = 1; nxt[5] = 1; end
            if (cur[4] && ev[3]) begin nxt[4] = 0; nxt[6] = 1; end
            if (cur[5] && ev[4]) begin nxt[5] = 0; nxt[7] = 1; end
            if (cur[6] && cur[7] && ev[5]) begin nxt[6] = 0; nxt[7] = 0; nxt[8] = 1; end
            if (cur[8]) begin
                nxt[8] = 0;
                if (ev[6])        nxt[0] = 1;
                else if (cond[7]) begin nxt[1] = 1; c = 2'b10; end
                else              begin nxt[0] = 1; c = 2'b01; end
            end
            m_step = nxt; m_cmd = c; m_prev = cond; m_started = 1'b1;
        end
        compare_on = 1'b1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle model comparison (R3, R10)
    always @(negedge clk) begin
        if (compare_on) begin
            check("R3 model step", 32'(step), 32'(m_step));
            check("R8 model cmd", 32'(cmd), 32'(m_cmd));
            check("R10 excl flag", 32'(excl), 32'd0);
        end
    end

    task automatic drive(input int idx, input bit v);
        cond[idx] = v;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    task automatic run_branches();
        drive(3, 1); check("R5 fork", 32'(step), 32'h030);
        @(negedge clk); check("R7 no cascade", 32'(step), 32'h030);
        drive(3, 0); check("R7 hold", 32'(step), 32'h030);
        drive(3, 1); check("R7 advance A", 32'(step), 32'h060);
        drive(3, 0);
        drive(4, 1); check("R6 branch B done", 32'(step), 32'h0C0);
        drive(4, 0);
    endtask

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        check("R1 reset step", 32'(step), 32'h000);
        check("R1 reset cmd", 32'(cmd), 32'h0);
        rst = 1'b0;
        @(negedge clk); check("R1 initial step", 32'(step), 32'h001);

        drive(1, 1); check("R2 unused edge", 32'(step), 32'h001);
        drive(0, 1); check("R3 start", 32'(step), 32'h002);
        drive(0, 0); check("R2 steady level", 32'(step), 32'h002);
        drive(1, 0); check("R2 falling edge", 32'(step), 32'h002);
        cond[1] = 1'b1; cond[2] = 1'b1;
        @(negedge clk); check("R4 left wins", 32'(step), 32'h004);
        cond[1] = 1'b0; cond[2] = 1'b0;
        @(negedge clk);

        drive(3, 1); check("R5 fork", 32'(step), 32'h030);
        @(negedge clk); check("R7 no cascade", 32'(step), 32'h030);
        drive(3, 0);
        drive(3, 1); check("R7 advance A", 32'(step), 32'h060);
        drive(3, 0);
        drive(5, 1); check("R6 join blocked", 32'(step), 32'h060);
        drive(5, 0);
        drive(4, 1); check("R6 branch B done", 32'(step), 32'h0C0);
        drive(4, 0);
        drive(5, 1); check("R6 join", 32'(step), 32'h100);
        check("R8 no cmd on entry", 32'(cmd), 32'h0);
        @(negedge clk); check("R8 finish step", 32'(step), 32'h001);
        check("R8 finish cmd", 32'(cmd), 32'h1);
        drive(5, 0); check("R8 pulse width", 32'(cmd), 32'h0);

        drive(0, 1); check("R3 start again", 32'(step), 32'h002);
        drive(0, 0);
        drive(2, 1); check("R4 right path", 32'(step), 32'h008);
        drive(2, 0);
        run_branches();
        cond[7] = 1'b1;
        drive(5, 1); check("R6 join right", 32'(step), 32'h100);
        @(negedge clk); check("R8 retry step", 32'(step), 32'h002);
        check("R8 retry cmd", 32'(cmd), 32'h2);
        drive(5, 0); check("R8 retry pulse width", 32'(cmd), 32'h0);

        drive(1, 1); check("R4 left again", 32'(step), 32'h004);
        drive(1, 0);
        run_branches();
        drive(5, 1); check("R6 join abort path", 32'(step), 32'h100);
        drive(6, 1); check("R9 abort step", 32'(step), 32'h001);
        check("R9 abort no cmd", 32'(cmd), 32'h0);
        drive(6, 0); check("R9 no late cmd", 32'(cmd), 32'h0);
        cond = '0;
        drive(5, 0);
        check("R10 flag final", 32'(excl), 32'h0);
        finish_run();
    end

endmodule